// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds a parameterised set of independent 32-bit interval timers behind a small word-addressed register bus. Each channel has a control word, a load word and a readable count. Software writes a start value and a control word with the run bit set, and the channel then counts down toward zero or up toward all-ones. It advances once for each cycle on which the prescale strobe `tick` is high.

When a channel reaches its terminal value it raises an expiry flag. If auto-reload is selected, the channel restarts from the load value. Otherwise it halts and holds its count. Software clears the flag by writing a one to the flag bit of the control word. A single interrupt output merges all channels, and each channel's contribution is gated by its own interrupt-enable bit.

The bus has one port. Reads are combinational from the current register state. A write takes effect at the clock edge on which `bus_we` is sampled high.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset (`rst` high), every control, load and count word reads zero, all channels are halted and `irq` is low.
- R2: Word address `a` selects channel `a>>2`. Low bits 0 select control, 1 select load and 2 select count. The count word is read-only, and writes to it are ignored. Word 3 of each channel reads zero, and writes to it are ignored.
- R3: Control bit positions are: 0 mode, 1 down-select, 2 generate, 3 capture, 4 auto-reload, 5 load, 6 interrupt-enable, 7 run, 8 expiry flag, 9 pulse-width, 10 enable-all. Bits 0 to 10 (except the flag) read back as written. Bits 11 to 31 read zero.
- R4: A control write with bit 7 set copies the load word into the count and starts the channel on the next clock. A control write with bit 7 clear halts the channel, and the count is held.
- R5: With bit 1 set, a running channel decrements by one on each tick. The channel expires on a tick that finds the count at zero.
- R6: With bit 1 clear, a running channel increments by one on each tick. The channel expires on a tick that finds the count at all-ones.
- R7: On expiry, bit 8 is set. If bit 4 is set, the count is reloaded from the load word and the channel keeps running. Otherwise the channel halts and holds its count.
- R8: A control write never sets bit 8. Writing a one to bit 8 clears it, and writing a zero leaves it unchanged.
- R9: `irq` is high exactly when some channel has both bit 8 and bit 6 set. It follows register changes from the clock edge of the write or expiry.
- R10: A channel's count changes only on a tick while the channel is running, or on a restarting control write. A control write to a channel overrides a tick in the same cycle.
- R11: Channels are independent. The channel count is the parameter `NCHAN`, which defaults to two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescale strobe; one count step per high cycle |
| bus_addr | input | AW (3 by default) | Word address: channel index above, register select in the low two bits |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Merged interrupt request |

## Verification
A corrupted count shows on the count word at the very next read. It also shows as an expiry that comes too early or too late, visible on the control flag and on `irq` one edge after the terminal tick. A wrong halt or reload state shows as a count that keeps moving, or stays frozen, under further ticks. A lost or wrongly set flag is visible on `irq` from the edge that caused it, while the interrupt-enable bit is set. The directed scenarios therefore read the count and control words right after each tick burst, so that any divergence is caught within one tick of its cause.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W     = 32;
  localparam int CTL_W     = 11;
  localparam int CB_MODE   = 0;
  localparam int CB_DOWN   = 1;
  localparam int CB_GEN    = 2;
  localparam int CB_CAP    = 3;
  localparam int CB_RELOAD = 4;
  localparam int CB_LDREQ  = 5;
  localparam int CB_IRQEN  = 6;
  localparam int CB_RUN    = 7;
  localparam int CB_FLAG   = 8;
  localparam int CB_PULSE  = 9;
  localparam int CB_ALL    = 10;

  // One count step in the selected direction.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic down);
    return down ? c - CNT_W'(1) : c + CNT_W'(1);
  endfunction

  // Terminal value reached for the selected direction.
  function automatic logic at_terminal(input logic [CNT_W-1:0] c, input logic down);
    return down ? (c == '0) : (&c);
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctl_we,
  input  logic             load_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_req
);
  logic [CTL_W-1:0] ctl_r, ctl_wr;
  logic [CNT_W-1:0] load_r, cnt_r;
  logic             run_r;
  logic             down;
  logic             expire;   // terminal tick event
  logic             step;     // ordinary count event

  assign down   = ctl_r[CB_DOWN];
  assign expire = run_r && tick && !ctl_we && at_terminal(cnt_r, down);
  assign step   = run_r && tick && !ctl_we && !expire;

  // Written control value: the flag may only be cleared by a write.
  always_comb begin
    ctl_wr          = wdata[CTL_W-1:0];
    ctl_wr[CB_FLAG] = ctl_r[CB_FLAG] & ~wdata[CB_FLAG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r  <= '0;
      load_r <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
    end else begin
      if (load_we) load_r <= wdata;
      if (ctl_we) begin
        ctl_r <= ctl_wr;
        run_r <= wdata[CB_RUN];
        if (wdata[CB_RUN]) cnt_r <= load_r;
      end else if (expire) begin
        ctl_r[CB_FLAG] <= 1'b1;
        if (ctl_r[CB_RELOAD]) cnt_r <= load_r;
        else                  run_r <= 1'b0;
      end else if (step) begin
        cnt_r <= step_count(cnt_r, down);
      end
    end
  end

  assign ctl_q   = ctl_r;
  assign load_q  = load_r;
  assign cnt_q   = cnt_r;
  assign irq_req = ctl_r[CB_FLAG] & ctl_r[CB_IRQEN];

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[CB_RUN]) |=> (cnt_q == $past(load_q) && run_r));
  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !wdata[CB_RUN]) |=> (!run_r && $stable(cnt_q)));
  assert_down_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run_r && tick && !ctl_we && ctl_q[CB_DOWN] && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_up_step_R6: assert property (@(posedge clk) disable iff (rst)
    (run_r && tick && !ctl_we && !ctl_q[CB_DOWN] && !(&cnt_q))
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_stop_on_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctl_q[CB_RELOAD]) |=> (!run_r && $stable(cnt_q) && ctl_q[CB_FLAG]));
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && ctl_q[CB_RELOAD]) |=> (run_r && cnt_q == load_q));
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[CB_FLAG]) |=> !ctl_q[CB_FLAG]);
  assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[CB_FLAG]) |-> $past(expire));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         irq
);
  assign irq = |req;

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(req) == 0) |-> !irq);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCHAN = 2,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int AW   = CH_W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam logic [1:0] W_CTL  = 2'd0;
  localparam logic [1:0] W_LOAD = 2'd1;
  localparam logic [1:0] W_CNT  = 2'd2;

  logic [CH_W-1:0]  ch_sel;
  logic [1:0]       word;
  logic [NCHAN-1:0] ctl_we_v, load_we_v, req_v;
  logic [CTL_W-1:0] ctl_a  [NCHAN];
  logic [CNT_W-1:0] load_a [NCHAN];
  logic [CNT_W-1:0] cnt_a  [NCHAN];

  assign ch_sel = bus_addr[AW-1:2];
  assign word   = bus_addr[1:0];

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    assign ctl_we_v[i]  = bus_we && (ch_sel == CH_W'(i)) && (word == W_CTL);
    assign load_we_v[i] = bus_we && (ch_sel == CH_W'(i)) && (word == W_LOAD);

    tmr_channel u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ctl_we  (ctl_we_v[i]),
      .load_we (load_we_v[i]),
      .wdata   (bus_wdata),
      .ctl_q   (ctl_a[i]),
      .load_q  (load_a[i]),
      .cnt_q   (cnt_a[i]),
      .irq_req (req_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCHAN; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (word)
          W_CTL:   bus_rdata = {{(32-CTL_W){1'b0}}, ctl_a[i]};
          W_LOAD:  bus_rdata = load_a[i];
          W_CNT:   bus_rdata = cnt_a[i];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  tmr_irq_merge #(.N(NCHAN)) u_irq (
    .clk (clk),
    .rst (rst),
    .req (req_v),
    .irq (irq)
  );

  assert_one_write_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_we_v, load_we_v}));
  assert_spare_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (word == 2'd3) |-> (bus_rdata == '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq));
endmodule

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_bank #(.NCHAN(2)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(3'd0, 32'h0, "R1 ctl0 after reset");
    rd(3'd1, 32'h0, "R1 load0 after reset");
    rd(3'd2, 32'h0, "R1 cnt0 after reset");
    rd(3'd4, 32'h0, "R1 ctl1 after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    ticks(3);
    rd(3'd2, 32'h0, "R1 halted after reset");
  endtask

  task automatic t_map;
    wr(3'd1, 32'h0000_1234);
    rd(3'd1, 32'h0000_1234, "R2 load0 readback");
    wr(3'd2, 32'h0000_0005);
    rd(3'd2, 32'h0, "R2 count word read-only");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'h0, "R2 spare word reads zero");
    wr(3'd4, 32'hFFFF_F77F);
    rd(3'd4, 32'h0000_067F, "R3 ctl1 bits and flag write");
    rd(3'd0, 32'h0, "R11 ctl0 untouched by ch1 write");
    wr(3'd4, 32'h0);
  endtask

  task automatic t_down;
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h0000_00C2);
    rd(3'd2, 32'd3, "R4 restart loads count");
    ticks(2);
    rd(3'd2, 32'd1, "R5 down two ticks");
    idle(3);
    rd(3'd2, 32'd1, "R10 no tick no change");
    ticks(1);
    rd(3'd0, 32'h0000_00C2, "R5 no expiry on reaching zero");
    ticks(1);
    rd(3'd0, 32'h0000_01C2, "R7 flag set at expiry");
    check("R9 irq after expiry", {31'b0, irq}, 32'h1);
    ticks(2);
    rd(3'd2, 32'd0, "R7 halted holds count");
  endtask

  task automatic t_flag;
    wr(3'd0, 32'h0000_0002);
    rd(3'd0, 32'h0000_0102, "R8 zero write keeps flag");
    check("R9 masked irq", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0000_0042);
    check("R9 unmasked irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0000_0142);
    rd(3'd0, 32'h0000_0042, "R8 one write clears flag");
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_up_reload;
    wr(3'd5, 32'hFFFF_FFFD);
    wr(3'd4, 32'h0000_00D0);
    ticks(2);
    rd(3'd6, 32'hFFFF_FFFF, "R6 up count to all-ones");
    rd(3'd4, 32'h0000_00D0, "R6 no expiry at all-ones yet");
    ticks(1);
    rd(3'd6, 32'hFFFF_FFFD, "R7 auto-reload");
    rd(3'd4, 32'h0000_01D0, "R7 flag on up expiry");
    check("R9 irq from ch1", {31'b0, irq}, 32'h1);
    rd(3'd2, 32'd0, "R11 ch0 unaffected");
    ticks(1);
    rd(3'd6, 32'hFFFF_FFFE, "R7 keeps running after reload");
  endtask

  task automatic t_halt;
    wr(3'd4, 32'h0000_0050);
    rd(3'd4, 32'h0000_0150, "R8 halt write keeps flag");
    ticks(3);
    rd(3'd6, 32'hFFFF_FFFE, "R4 halted holds count");
    wr(3'd4, 32'h0000_0150);
    check("R9 irq low after ch1 clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_precedence;
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h0000_0082);
    ticks(3);
    rd(3'd2, 32'd7, "R5 down three ticks");
    wr_tick(3'd0, 32'h0000_0082);
    rd(3'd2, 32'd10, "R10 write overrides tick");
    ticks(1);
    rd(3'd2, 32'd9, "R10 counting resumes");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_down();
    t_flag();
    t_up_reload();
    t_halt();
    t_precedence();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule